// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches two streams from a processor core and flags breakpoint hits for the debug logic. The first stream is the address of every transfer on the core's local bus. That address is compared against a pair of programmable bounds. A trigger-mode input selects one of three checks: an exact match against the low bound, a hit anywhere inside the inclusive range, or a hit anywhere outside that range. The second stream is the program counter. It is compared against a programmed breakpoint value under a per-bit mask, where a 1 in the mask removes that bit from the compare.

The four breakpoint registers are 32 bits wide and can only be written. Each is selected by a 5-bit register code on a single write port. A write is accepted only when it is marked as coming from supervisor mode or from the debug port. Any other write is dropped.

Each comparator has its own enable input. Each hit flag is registered, and it is high only in the cycle that follows a qualifying strobe.

Top module: `brk_match_unit`

## Requirements
- R1: After reset, all four breakpoint registers hold zero and both hit outputs are low.
- R2: A write with `wr_en` high and at least one of `wr_sup`/`wr_dbg` high loads `wr_data` at the clock edge. The code selects the register: 0x08 is the PC breakpoint value, 0x09 the PC mask, 0x0C the high address bound and 0x0D the low address bound. The new value applies to strobes in later cycles.
- R3: A write with `wr_sup` and `wr_dbg` both low changes no register.
- R4: A write carrying any code other than the four listed in R2 changes no register.
- R5: In mode 2'b00 (exact), an address hit needs the bus address to equal the low bound. The high bound plays no part.
- R6: In mode 2'b01 (inside), an address hit needs low <= address <= high, both bounds inclusive.
- R7: In mode 2'b10 (outside), an address hit needs address < low or address > high.
- R8: When low > high, inside mode never hits and outside mode hits every address.
- R9: Mode 2'b11 never produces an address hit.
- R10: A PC hit needs every PC bit whose mask bit is 0 to equal the breakpoint bit. Bits whose mask bit is 1 are ignored.
- R11: `addr_hit` (or `pc_hit`) is high exactly in the cycle after a cycle with `bus_valid` (or `pc_valid`) high and a match. It is low after any cycle without that strobe.
- R12: While `addr_en` (or `pc_en`) is low, the matching hit output stays low whatever the strobe and values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_code | input | 5 | Register code of the write |
| wr_data | input | 32 | Write data |
| wr_sup | input | 1 | Write issued from supervisor mode |
| wr_dbg | input | 1 | Write issued through the debug port |
| trig_mode | input | 2 | Address match mode: 00 exact, 01 inside, 10 outside, 11 none |
| addr_en | input | 1 | Address comparator enable |
| pc_en | input | 1 | PC comparator enable |
| bus_valid | input | 1 | Local-bus transfer present this cycle |
| bus_addr | input | 32 | Local-bus transfer address |
| pc_valid | input | 1 | PC value present this cycle |
| pc_val | input | 32 | Current program counter |
| addr_hit | output | 1 | Registered address breakpoint hit |
| pc_hit | output | 1 | Registered PC breakpoint hit |

## Verification
The assertions assume that every input is at a defined value on each clock edge once reset is released, and that the trigger mode and enables are held steady for the whole cycle of the strobe they qualify. They also assume that a register write and a strobe that depends on it never fall in the same cycle. The compare uses the value registered before the edge, so the expected result in that cycle would be ambiguous. The bench drives every input once per cycle, at the falling edge, with the mode and enables passed alongside each strobe. Each write is issued in a cycle of its own with both strobes low.

// File: rtl/brk_pkg.sv
package brk_pkg;
   localparam int CODE_W = 5;

   localparam logic [CODE_W-1:0] CODE_PC_VAL  = 5'h08;
   localparam logic [CODE_W-1:0] CODE_PC_MASK = 5'h09;
   localparam logic [CODE_W-1:0] CODE_ADDR_HI = 5'h0C;
   localparam logic [CODE_W-1:0] CODE_ADDR_LO = 5'h0D;

   typedef enum logic [1:0] {
      TRIG_EXACT   = 2'b00,
      TRIG_INSIDE  = 2'b01,
      TRIG_OUTSIDE = 2'b10,
      TRIG_NONE    = 2'b11
   } trig_mode_e;
endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
   import brk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [31:0]       wr_data,
   input  logic              wr_sup,
   input  logic              wr_dbg,
   output logic [ADDR_W-1:0] lo_q,
   output logic [ADDR_W-1:0] hi_q,
   output logic [PC_W-1:0]   pcv_q,
   output logic [PC_W-1:0]   pcm_q
);
   logic wr_ok;
   logic sel_lo, sel_hi, sel_pcv, sel_pcm;

   always_comb begin
      wr_ok   = wr_en && (wr_sup || wr_dbg);
      sel_lo  = wr_ok && (wr_code == CODE_ADDR_LO);
      sel_hi  = wr_ok && (wr_code == CODE_ADDR_HI);
      sel_pcv = wr_ok && (wr_code == CODE_PC_VAL);
      sel_pcm = wr_ok && (wr_code == CODE_PC_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         pcv_q <= '0;
         pcm_q <= '0;
      end else begin
         if (sel_lo)  lo_q  <= wr_data[ADDR_W-1:0];
         if (sel_hi)  hi_q  <= wr_data[ADDR_W-1:0];
         if (sel_pcv) pcv_q <= wr_data[PC_W-1:0];
         if (sel_pcm) pcm_q <= wr_data[PC_W-1:0];
      end
   end
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
   import brk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              enable,
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              hit
);
   logic eq_lo, ge_lo, le_hi, in_rng, match;

   always_comb begin
      eq_lo  = (addr == lo);
      ge_lo  = (addr >= lo);
      le_hi  = (addr <= hi);
      in_rng = ge_lo && le_hi;
      unique case (trig_mode_e'(mode))
         TRIG_EXACT:   match = eq_lo;
         TRIG_INSIDE:  match = in_rng;
         TRIG_OUTSIDE: match = !in_rng;
         default:      match = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= valid && enable && match;
   end
endmodule

// File: rtl/brk_pc_cmp.sv
module brk_pc_cmp #(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            valid,
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] bp,
   input  logic [PC_W-1:0] mask,
   output logic            hit
);
   logic [PC_W-1:0] bit_ok;

   for (genvar i = 0; i < PC_W; i++) begin : g_bit
      assign bit_ok[i] = mask[i] || (pc[i] == bp[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= valid && enable && (&bit_ok);
   end
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
   import brk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wr_code,
   input  logic [31:0]       wr_data,
   input  logic              wr_sup,
   input  logic              wr_dbg,
   input  logic [1:0]        trig_mode,
   input  logic              addr_en,
   input  logic              pc_en,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              pc_valid,
   input  logic [PC_W-1:0]   pc_val,
   output logic              addr_hit,
   output logic              pc_hit
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_chk_aw
      $error("brk_match_unit: ADDR_W must be 1..32");
   end
   if (PC_W < 1 || PC_W > 32) begin : g_chk_pw
      $error("brk_match_unit: PC_W must be 1..32");
   end

   logic [ADDR_W-1:0] lo_q, hi_q;
   logic [PC_W-1:0]   pcv_q, pcm_q;

   brk_regfile #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
      .wr_sup(wr_sup), .wr_dbg(wr_dbg),
      .lo_q(lo_q), .hi_q(hi_q), .pcv_q(pcv_q), .pcm_q(pcm_q)
   );

   brk_addr_cmp #(.ADDR_W(ADDR_W)) u_acmp (
      .clk(clk), .rst_n(rst_n), .mode(trig_mode), .enable(addr_en),
      .valid(bus_valid), .addr(bus_addr), .lo(lo_q), .hi(hi_q),
      .hit(addr_hit)
   );

   brk_pc_cmp #(.PC_W(PC_W)) u_pcmp (
      .clk(clk), .rst_n(rst_n), .enable(pc_en), .valid(pc_valid),
      .pc(pc_val), .bp(pcv_q), .mask(pcm_q), .hit(pc_hit)
   );
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk #(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [4:0]        wr_code,
   input logic [31:0]       wr_data,
   input logic              wr_sup,
   input logic              wr_dbg,
   input logic [1:0]        trig_mode,
   input logic              addr_en,
   input logic              pc_en,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              pc_valid,
   input logic [PC_W-1:0]   pc_val,
   input logic              addr_hit,
   input logic              pc_hit,
   input logic [ADDR_W-1:0] lo_q,
   input logic [ADDR_W-1:0] hi_q,
   input logic [PC_W-1:0]   pcv_q,
   input logic [PC_W-1:0]   pcm_q
);
   logic known_code, addr_go;
   assign known_code = (wr_code == 5'h08) || (wr_code == 5'h09) ||
                       (wr_code == 5'h0C) || (wr_code == 5'h0D);
   assign addr_go = bus_valid && addr_en;

   p_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sup || wr_dbg) && wr_code == 5'h0D) |=> lo_q == $past(wr_data[ADDR_W-1:0]));

   p_reject_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sup && !wr_dbg) |=>
      ($stable(lo_q) && $stable(hi_q) && $stable(pcv_q) && $stable(pcm_q)));

   p_reject_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !known_code) |=>
      ($stable(lo_q) && $stable(hi_q) && $stable(pcv_q) && $stable(pcm_q)));

   p_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_go && trig_mode == 2'b00) |=> addr_hit == ($past(bus_addr) == $past(lo_q)));

   p_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_go && trig_mode == 2'b01) |=>
      addr_hit == ($past(bus_addr) >= $past(lo_q) && $past(bus_addr) <= $past(hi_q)));

   p_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_go && trig_mode == 2'b10) |=>
      addr_hit == ($past(bus_addr) < $past(lo_q) || $past(bus_addr) > $past(hi_q)));

   p_none_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode == 2'b11) |=> !addr_hit);

   p_pc_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_valid && pc_en) |=>
      pc_hit == ((($past(pc_val) ^ $past(pcv_q)) & ~$past(pcm_q)) == '0));

   p_addr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !addr_hit);

   p_pc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_valid |=> !pc_hit);

   p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_en || !pc_en) |=> (!(!$past(addr_en) && addr_hit) && !(!$past(pc_en) && pc_hit)));
endmodule

bind brk_match_unit brk_match_chk #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
   .wr_data(wr_data), .wr_sup(wr_sup), .wr_dbg(wr_dbg),
   .trig_mode(trig_mode), .addr_en(addr_en), .pc_en(pc_en),
   .bus_valid(bus_valid), .bus_addr(bus_addr), .pc_valid(pc_valid),
   .pc_val(pc_val), .addr_hit(addr_hit), .pc_hit(pc_hit),
   .lo_q(lo_q), .hi_q(hi_q), .pcv_q(pcv_q), .pcm_q(pcm_q)
);

// File: tb/sim_brk_match_unit.sv
`timescale 1ns/1ps
module sim_brk_match_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_code = '0;
   logic [31:0] wr_data = '0;
   logic        wr_sup = 1'b0, wr_dbg = 1'b0;
   logic [1:0]  trig_mode = 2'b00;
   logic        addr_en = 1'b0, pc_en = 1'b0;
   logic        bus_valid = 1'b0, pc_valid = 1'b0;
   logic [31:0] bus_addr = '0, pc_val = '0;
   logic        addr_hit, pc_hit;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   typedef struct {
      bit    is_pc;
      bit    exp;
      string tag;
   } item_t;
   item_t sbq[$];

   logic [31:0] m_lo = '0, m_hi = '0, m_pcv = '0, m_pcm = '0;

   brk_match_unit u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
      .wr_data(wr_data), .wr_sup(wr_sup), .wr_dbg(wr_dbg),
      .trig_mode(trig_mode), .addr_en(addr_en), .pc_en(pc_en),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .pc_valid(pc_valid),
      .pc_val(pc_val), .addr_hit(addr_hit), .pc_hit(pc_hit)
   );

   always #5 clk = ~clk;

   task automatic check(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic bit exp_addr(input logic [1:0] m, input logic [31:0] a);
      case (m)
         2'b00:   return a == m_lo;
         2'b01:   return (a >= m_lo) && (a <= m_hi);
         2'b10:   return (a < m_lo) || (a > m_hi);
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit exp_pc(input logic [31:0] p);
      return ((p ^ m_pcv) & ~m_pcm) == 32'h0;
   endfunction

   // monitor: compare after each rising edge everything pushed before it
   always @(posedge clk) begin
      #1;
      while (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         check(it.is_pc ? pc_hit : addr_hit, it.exp, it.tag);
      end
   end

   task automatic step(input logic [1:0] m, input bit aen, input bit bv,
                       input logic [31:0] a, input bit pen, input bit pv,
                       input logic [31:0] p, input string tag);
      item_t ia, ip;
      @(negedge clk);
      wr_en = 0; wr_sup = 0; wr_dbg = 0;
      trig_mode = m; addr_en = aen; bus_valid = bv; bus_addr = a;
      pc_en = pen; pc_valid = pv; pc_val = p;
      ia.is_pc = 0; ia.exp = bv && aen && exp_addr(m, a); ia.tag = {tag, " addr_hit"};
      ip.is_pc = 1; ip.exp = pv && pen && exp_pc(p);      ip.tag = {tag, " pc_hit"};
      sbq.push_back(ia);
      sbq.push_back(ip);
   endtask

   task automatic wr(input bit sup, input bit dbg, input logic [4:0] code,
                     input logic [31:0] d);
      @(negedge clk);
      bus_valid = 0; pc_valid = 0;
      wr_en = 1; wr_sup = sup; wr_dbg = dbg; wr_code = code; wr_data = d;
      if (sup || dbg) begin
         case (code)
            5'h08: m_pcv = d;
            5'h09: m_pcm = d;
            5'h0C: m_hi  = d;
            5'h0D: m_lo  = d;
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(addr_hit, 1'b0, "R1 reset addr_hit");
      check(pc_hit, 1'b0, "R1 reset pc_hit");
      @(negedge clk);
      rst_n = 1;

      // R1: zeroed registers
      step(2'b00, 1, 1, 32'h0, 1, 1, 32'h0, "R1 zero regs match");
      step(2'b00, 1, 1, 32'h5, 1, 1, 32'h4, "R1 zero regs miss");

      // R2: writes through both accepted sources
      wr(1, 0, 5'h0D, 32'h0000_1000);
      wr(1, 0, 5'h0C, 32'h0000_1FFF);
      wr(0, 1, 5'h08, 32'h8000_0040);
      wr(0, 1, 5'h09, 32'h0000_000F);
      step(2'b00, 1, 1, 32'h0000_1000, 1, 1, 32'h8000_0040, "R2 written values");

      // R5 exact
      step(2'b00, 1, 1, 32'h0000_1001, 0, 0, 0, "R5 exact above");
      step(2'b00, 1, 1, 32'h0000_0FFF, 0, 0, 0, "R5 exact below");
      step(2'b00, 1, 1, 32'h0000_1FFF, 0, 0, 0, "R5 exact at high bound");

      // R6 inside
      step(2'b01, 1, 1, 32'h0000_1000, 0, 0, 0, "R6 inside low edge");
      step(2'b01, 1, 1, 32'h0000_1FFF, 0, 0, 0, "R6 inside high edge");
      step(2'b01, 1, 1, 32'h0000_1800, 0, 0, 0, "R6 inside middle");
      step(2'b01, 1, 1, 32'h0000_0FFF, 0, 0, 0, "R6 inside below");
      step(2'b01, 1, 1, 32'h0000_2000, 0, 0, 0, "R6 inside above");

      // R7 outside
      step(2'b10, 1, 1, 32'h0000_1000, 0, 0, 0, "R7 outside low edge");
      step(2'b10, 1, 1, 32'h0000_1FFF, 0, 0, 0, "R7 outside high edge");
      step(2'b10, 1, 1, 32'h0000_0FFF, 0, 0, 0, "R7 outside below");
      step(2'b10, 1, 1, 32'h0000_2000, 0, 0, 0, "R7 outside above");

      // R9 reserved mode
      step(2'b11, 1, 1, 32'h0000_1000, 0, 0, 0, "R9 mode 11 on low");
      step(2'b11, 1, 1, 32'h0000_0000, 0, 0, 0, "R9 mode 11 on zero");

      // R10 masked PC compare
      step(2'b00, 0, 0, 0, 1, 1, 32'h8000_004F, "R10 masked bits differ");
      step(2'b00, 0, 0, 0, 1, 1, 32'h8000_0050, "R10 unmasked bit4 differs");
      step(2'b00, 0, 0, 0, 1, 1, 32'h0000_0040, "R10 unmasked bit31 differs");

      // R3 dropped write from neither source
      wr(0, 0, 5'h0D, 32'h0000_3000);
      step(2'b00, 1, 1, 32'h0000_1000, 0, 0, 0, "R3 old low kept");
      step(2'b00, 1, 1, 32'h0000_3000, 0, 0, 0, "R3 new low not taken");
      wr(0, 0, 5'h09, 32'hFFFF_FFFF);
      step(2'b00, 0, 0, 0, 1, 1, 32'h0000_0040, "R3 mask not taken");

      // R4 unknown codes
      wr(1, 1, 5'h0A, 32'h0000_0000);
      wr(1, 0, 5'h0E, 32'h0000_0000);
      wr(0, 1, 5'h1D, 32'h0000_0000);
      step(2'b00, 1, 1, 32'h0000_1000, 1, 1, 32'h8000_0040, "R4 regs unchanged");
      step(2'b01, 1, 1, 32'h0000_1FFF, 1, 1, 32'h8000_0050, "R4 high unchanged");

      // R8 inverted bounds
      wr(1, 0, 5'h0D, 32'h0000_5000);
      wr(0, 1, 5'h0C, 32'h0000_4000);
      step(2'b01, 1, 1, 32'h0000_4800, 0, 0, 0, "R8 inside inverted mid");
      step(2'b01, 1, 1, 32'h0000_5000, 0, 0, 0, "R8 inside inverted low");
      step(2'b10, 1, 1, 32'h0000_4800, 0, 0, 0, "R8 outside inverted mid");
      step(2'b10, 1, 1, 32'h0000_0000, 0, 0, 0, "R8 outside inverted zero");
      step(2'b10, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R8 outside inverted top");

      // R12 enables
      step(2'b10, 0, 1, 32'h0000_0000, 0, 1, 32'h8000_0040, "R12 disabled");
      step(2'b10, 1, 1, 32'h0000_0000, 1, 1, 32'h8000_0040, "R12 re-enabled");

      // R11 strobe qualification and one-cycle timing
      step(2'b10, 1, 0, 32'h0000_0000, 1, 0, 32'h8000_0040, "R11 no strobe");
      step(2'b10, 1, 1, 32'h0000_0000, 1, 1, 32'h8000_0040, "R11 strobe again");
      step(2'b10, 1, 0, 32'h0000_0000, 1, 0, 32'h8000_0040, "R11 drop after one");

      @(negedge clk);
      bus_valid = 0; pc_valid = 0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule